// File: doc/BRIEF.md
# Flash Register Write-Guard

This block holds the protection state of a serial NOR flash, namely the first status byte and the configuration byte. It decides whether each register write or array modification may go ahead. Its inputs are commands that have already been decoded, each a one-cycle strobe: set the write-enable latch, clear it, write both registers from two data bytes, and program or erase at a given array address. It also takes the active-low hardware write-protect pin.

A register write is refused when the write-enable latch is clear. It is also refused when the register-lock bit is set, the protect pin is low and quad mode is off. In quad mode the protect pin is a data line, so it cannot guard anything. A 3-bit block-protect field marks a run of top sectors as protected. The block reports combinationally whether the presented address falls in that run. Program or erase at such an address is refused.

Every decision is reported with a one-cycle accept or reject pulse. The power-up register contents are parameters, which stand in for non-volatile retention. At most one command strobe is expected per cycle. If several arrive together, the order of precedence is register write, then program or erase, then latch clear, then latch set.

Top module: `flash_reg_guard`

## Requirements
- R1: After reset, status bit 7 and bits 4:2 take their values from SR1_INIT, and every other status bit reads 0. The configuration byte equals CR_INIT. Both defaults are zero, and all four pulse outputs are low.
- R2: A write-enable strobe sets status bit 1 (the write-enable latch) at the clock edge that samples it. A write-disable strobe clears that bit.
- R3: A register-write strobe while status bit 1 is 0 is rejected, and neither register changes.
- R4: A register-write strobe is rejected, leaving both registers unchanged, when status bit 7 (the lock bit) is 1, wp_n is 0 and configuration bit 1 is 0.
- R5: When status bit 1 is 1, status bit 7 is 1 and wp_n is 1, a register write is accepted. Status bits 7 and 4:2 then take the same bits of wrr_sr1, and the configuration byte takes wrr_cr.
- R6: When status bit 7 is 0, the level of wp_n does not affect the outcome of a register write.
- R7: When configuration bit 1 (quad enable) is 1, wp_n does not affect the outcome of a register write, even with status bit 7 set.
- R8: Status bits 0, 1, 5 and 6 are never loaded from wrr_sr1. Bits 0, 5 and 6 always read 0. Status bit 1 is cleared after every register-write strobe, whether that write is accepted or rejected.
- R9: addr_protected is 1 exactly when req_addr lies in the protected region. The sector index is the top SECT_LOG2 address bits, and the block-protect field is status bits 4:2. A field value of 0 protects nothing. A value k from 1 to 6 protects the top 2^(k-1) sectors, capped at the whole array. A value of 7 protects every sector.
- R10: A program or erase strobe is accepted when status bit 1 is 1 and addr_protected is 0, and rejected otherwise. Status bit 1 is cleared after either outcome.
- R11: The cycle after each register-write strobe, exactly one of wrr_accept and wrr_reject is high, for one cycle only. The same holds for pe_accept and pe_reject after each program or erase strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrr | input | 1 | Register-write strobe |
| wrr_sr1 | input | 8 | Status data for a register write |
| wrr_cr | input | 8 | Configuration data for a register write |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| cmd_prog | input | 1 | Program strobe |
| cmd_erase | input | 1 | Erase strobe |
| req_addr | input | ADDR_W | Array address of program, erase or query |
| sr1 | output | 8 | Current status byte |
| cr | output | 8 | Current configuration byte |
| addr_protected | output | 1 | req_addr lies in the protected region |
| wrr_accept | output | 1 | Pulse: register write accepted |
| wrr_reject | output | 1 | Pulse: register write refused |
| pe_accept | output | 1 | Pulse: program or erase accepted |
| pe_reject | output | 1 | Pulse: program or erase refused |

## Verification
Each command strobe is registered at one rising edge. Its register update and its accept or reject pulse are due in the cycle that follows. The bench drives every strobe at a falling edge and removes it at the next falling edge, then compares sr1, cr and all four pulses there, half a cycle after the edge that took the command. addr_protected is combinational, so it is checked 1 ns after the address changes, before any edge. The bench also samples the pulses one more cycle later to confirm that they last one cycle only.

// File: rtl/flash_reg_guard.sv
`timescale 1ns/1ps
module flash_reg_guard #(
  parameter int         ADDR_W    = 20,
  parameter int         SECT_LOG2 = 6,
  parameter logic [7:0] SR1_INIT  = 8'h00,
  parameter logic [7:0] CR_INIT   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrr,
  input  logic [7:0]        wrr_sr1,
  input  logic [7:0]        wrr_cr,
  input  logic              wp_n,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        sr1,
  output logic [7:0]        cr,
  output logic              addr_protected,
  output logic              wrr_accept,
  output logic              wrr_reject,
  output logic              pe_accept,
  output logic              pe_reject
);

  localparam logic [SECT_LOG2:0] NSECT = {1'b1, {SECT_LOG2{1'b0}}};

  logic       lock_q;
  logic [2:0] bp_q;
  logic       wel_q;
  logic [7:0] cr_q;

  logic [SECT_LOG2-1:0] sect;
  logic [SECT_LOG2:0]   span;
  logic                 unused_bits;

  assign unused_bits = ^{wrr_sr1[6:5], wrr_sr1[1:0]};

  wire quad_on  = cr_q[1];
  wire pin_lock = lock_q & ~wp_n & ~quad_on;
  wire wrr_ok   = wel_q & ~pin_lock;
  wire pe_cmd   = cmd_prog | cmd_erase;
  wire pe_ok    = wel_q & ~addr_protected;

  assign sect = req_addr[ADDR_W-1 -: SECT_LOG2];

  always_comb begin
    if (bp_q == 3'd0)
      span = '0;
    else if (bp_q == 3'd7 || int'(bp_q) > SECT_LOG2)
      span = NSECT;
    else
      span = {{SECT_LOG2{1'b0}}, 1'b1} << (bp_q - 3'd1);
  end

  assign addr_protected = (span != '0) && ({1'b0, sect} >= (NSECT - span));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= SR1_INIT[7];
      bp_q       <= SR1_INIT[4:2];
      wel_q      <= 1'b0;
      cr_q       <= CR_INIT;
      wrr_accept <= 1'b0;
      wrr_reject <= 1'b0;
      pe_accept  <= 1'b0;
      pe_reject  <= 1'b0;
    end else begin
      wrr_accept <= 1'b0;
      wrr_reject <= 1'b0;
      pe_accept  <= 1'b0;
      pe_reject  <= 1'b0;
      if (cmd_wrr) begin
        wrr_accept <= wrr_ok;
        wrr_reject <= ~wrr_ok;
        wel_q      <= 1'b0;
        if (wrr_ok) begin
          lock_q <= wrr_sr1[7];
          bp_q   <= wrr_sr1[4:2];
          cr_q   <= wrr_cr;
        end
      end else if (pe_cmd) begin
        pe_accept <= pe_ok;
        pe_reject <= ~pe_ok;
        wel_q     <= 1'b0;
      end else if (cmd_wrdi) begin
        wel_q <= 1'b0;
      end else if (cmd_wren) begin
        wel_q <= 1'b1;
      end
    end
  end

  assign sr1 = {lock_q, 2'b00, bp_q, wel_q, 1'b0};
  assign cr  = cr_q;

endmodule

// File: rtl/flash_reg_guard_chk.sv
`timescale 1ns/1ps
module flash_reg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_wrr,
  input logic       wp_n,
  input logic       cmd_prog,
  input logic       cmd_erase,
  input logic [7:0] sr1,
  input logic [7:0] cr,
  input logic       addr_protected,
  input logic       wrr_accept,
  input logic       wrr_reject,
  input logic       pe_accept,
  input logic       pe_reject
);

  wire single = $onehot({cmd_wren, cmd_wrdi, cmd_wrr, cmd_prog, cmd_erase});

  assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    single && cmd_wren |=> sr1[1]);
  assert_wel_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    single && cmd_wrdi |=> !sr1[1]);
  assert_no_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    single && cmd_wrr && !sr1[1] |=> wrr_reject && $stable(cr) && $stable(sr1[7:2]));
  assert_pin_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    single && cmd_wrr && sr1[7] && !wp_n && !cr[1] |=> wrr_reject && $stable(cr) && $stable(sr1[7:2]));
  assert_pin_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    single && cmd_wrr && sr1[1] && wp_n |=> wrr_accept);
  assert_lock_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    single && cmd_wrr && sr1[1] && !sr1[7] |=> wrr_accept);
  assert_quad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    single && cmd_wrr && sr1[1] && cr[1] |=> wrr_accept);
  assert_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sr1[0] && sr1[6:5] == 2'b00);
  assert_wel_after_wrr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrr |=> !sr1[1]);
  assert_prot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    single && (cmd_prog || cmd_erase) && addr_protected |=> pe_reject);
  assert_pe_wel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    single && (cmd_prog || cmd_erase) && !sr1[1] |=> pe_reject && !sr1[1]);
  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrr_accept && wrr_reject) && !(pe_accept && pe_reject));
  assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wrr_accept || wrr_reject) |-> $past(cmd_wrr));

endmodule

bind flash_reg_guard flash_reg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
  .cmd_wrr(cmd_wrr), .wp_n(wp_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
  .sr1(sr1), .cr(cr), .addr_protected(addr_protected),
  .wrr_accept(wrr_accept), .wrr_reject(wrr_reject),
  .pe_accept(pe_accept), .pe_reject(pe_reject)
);

// File: tb/flash_reg_guard_tb.sv
`timescale 1ns/1ps
module flash_reg_guard_tb;
  localparam int ADDR_W = 20;
  localparam int SECT_LOG2 = 6;
  localparam int NS = 1 << SECT_LOG2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrr = 0, cmd_prog = 0, cmd_erase = 0;
  logic [7:0] wrr_sr1 = 0, wrr_cr = 0;
  logic wp_n = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] sr1, cr;
  logic addr_protected, wrr_accept, wrr_reject, pe_accept, pe_reject;

  int checks = 0;
  int errors = 0;

  logic       m_lock;
  logic [2:0] m_bp;
  logic       m_wel;
  logic [7:0] m_cr;

  always #4 clk = ~clk;

  flash_reg_guard #(.ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrr(cmd_wrr), .wrr_sr1(wrr_sr1), .wrr_cr(wrr_cr), .wp_n(wp_n),
    .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .req_addr(req_addr),
    .sr1(sr1), .cr(cr), .addr_protected(addr_protected),
    .wrr_accept(wrr_accept), .wrr_reject(wrr_reject),
    .pe_accept(pe_accept), .pe_reject(pe_reject));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sr1();
    return {m_lock, 2'b00, m_bp, m_wel, 1'b0};
  endfunction

  function automatic logic exp_prot(logic [2:0] bp, logic [ADDR_W-1:0] a);
    int idx = int'(a >> (ADDR_W - SECT_LOG2));
    int span;
    if (bp == 3'd0) return 1'b0;
    if (bp == 3'd7) return 1'b1;
    span = 1 << (int'(bp) - 1);
    if (span >= NS) return 1'b1;
    return idx >= NS - span;
  endfunction

  task automatic check_regs(string req);
    check({req, " sr1"}, 32'(sr1), 32'(exp_sr1()));
    check({req, " cr"}, 32'(cr), 32'(m_cr));
  endtask

  task automatic pulse_strobe(int kind);
    @(negedge clk);
    case (kind)
      0: cmd_wren = 1;
      1: cmd_wrdi = 1;
      2: cmd_wrr = 1;
      3: cmd_prog = 1;
      default: cmd_erase = 1;
    endcase
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrr, cmd_prog, cmd_erase} = '0;
  endtask

  task automatic do_wren();
    pulse_strobe(0);
    m_wel = 1;
    check_regs("R2 wren");
  endtask

  task automatic do_wrdi();
    pulse_strobe(1);
    m_wel = 0;
    check_regs("R2 wrdi");
  endtask

  task automatic do_wrr(logic [7:0] d_sr, logic [7:0] d_cr, logic pin);
    string tag;
    logic ok;
    @(negedge clk);
    wrr_sr1 = d_sr; wrr_cr = d_cr; wp_n = pin;
    if (!m_wel) tag = "R3";
    else if (m_lock && !pin && !m_cr[1]) tag = "R4";
    else if (m_lock && !pin) tag = "R7";
    else if (!m_lock) tag = "R6";
    else tag = "R5";
    ok = m_wel && !(m_lock && !pin && !m_cr[1]);
    pulse_strobe(2);
    if (ok) begin
      m_lock = d_sr[7]; m_bp = d_sr[4:2]; m_cr = d_cr;
    end
    m_wel = 0;
    check_regs({tag, "/R8 wrr"});
    check({tag, "/R11 wrr pulses"}, {30'd0, wrr_accept, wrr_reject}, {30'd0, ok, !ok});
  endtask

  task automatic do_pe(logic erase, logic [ADDR_W-1:0] a);
    logic prot;
    logic ok;
    @(negedge clk);
    req_addr = a;
    #1;
    prot = exp_prot(m_bp, a);
    check("R9 addr_protected", 32'(addr_protected), 32'(prot));
    ok = m_wel && !prot;
    pulse_strobe(erase ? 4 : 3);
    m_wel = 0;
    check_regs("R10 pe");
    check("R10/R11 pe pulses", {30'd0, pe_accept, pe_reject}, {30'd0, ok, !ok});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_lock = 0; m_bp = 0; m_wel = 0; m_cr = 0;
    repeat (3) @(negedge clk);
    check_regs("R1 reset");
    check("R1 pulses", {28'd0, wrr_accept, wrr_reject, pe_accept, pe_reject}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    do_wren();
    do_wrdi();
    do_wrr(8'h9C, 8'h00, 1'b1);
    do_wren();
    do_wrr(8'h80, 8'h00, 1'b1);
    do_wren();
    do_wrr(8'h1C, 8'h55, 1'b0);
    do_wren();
    do_wrr(8'h84, 8'hA0, 1'b1);
    @(negedge clk);
    check("R11 pulse width", {30'd0, wrr_accept, wrr_reject}, 32'd0);
    do_wren();
    do_wrr(8'h88, 8'h02, 1'b1);
    do_wren();
    do_wrr(8'hFF, 8'h03, 1'b0);
    check("R8 fixed bits", 32'(sr1 & 8'h63), 32'd0);
    do_wren();
    do_wrr(8'h00, 8'h00, 1'b1);
    do_wren();
    do_wrr(8'h10, 8'h00, 1'b0);

    for (int bp = 0; bp < 8; bp++) begin
      do_wren();
      do_wrr(8'(bp << 2), 8'h00, 1'b1);
      for (int s = 0; s < NS; s += 7) begin
        do_wren();
        do_pe(s[0], ADDR_W'((s << (ADDR_W - SECT_LOG2)) | (s * 13)));
      end
      do_pe(1'b0, {ADDR_W{1'b1}});
    end

    for (int i = 0; i < 1500; i++) begin
      int k = int'($urandom % 7);
      logic [ADDR_W-1:0] a = ADDR_W'($urandom);
      if ($urandom % 2 == 0) a[ADDR_W-1 -: 2] = 2'b11;
      case (k)
        0, 1: do_wren();
        2: do_wrdi();
        3, 4: do_wrr(8'($urandom), 8'($urandom), 1'($urandom));
        default: do_pe(1'($urandom), a);
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule